// File: doc/BRIEF.md
# Banked DRAM Address Multiplexer

This block turns a CPU access into the strobe and address sequence for a DRAM array that has a 9-bit multiplexed address bus and two byte lanes. The CPU supplies a 13-bit offset inside an 8 KB page. A page-mapping stage supplies a 5-bit bank number. Together these form an 18-bit physical address.

Bit 0 of that address is not placed on the DRAM address bus. It picks which of the two byte-lane write enables is used. The remaining 17 bits are scattered over a row word and a column word. The top bank bit appears in both words. A small sequencer steps through the phases of each access: address setup, row strobe, address switch, column strobe and precharge.

The sequencer accepts one request at a time. It reports busy until precharge has finished.

Top module: `dram_addr_mux`

## Requirements
- R1: While reset is held and after it is released, ras_no, cas_no, we0_no and we1_no are all high, busy_o is low and dram_addr_o is zero.
- R2: The row word has dram_addr_o[7:0] = cpu_addr_i[8:1] and dram_addr_o[8] = bank_i[4].
- R3: The column word has dram_addr_o[3:0] = cpu_addr_i[12:9], dram_addr_o[7:4] = bank_i[3:0] and dram_addr_o[8] = bank_i[4].
- R4: On a write with cpu_addr_i[0] = 0, only we0_no goes low. With cpu_addr_i[0] = 1, only we1_no goes low. The active enable falls one clock before cas_no falls and rises together with cas_no. On a read, both enables stay high.
- R5: ras_no falls only at a clock edge where phase_e_i is sampled high. While the block waits for that edge, ras_no stays high and the row word is on the bus.
- R6: The row word is on the bus in the cycle before ras_no falls and in the cycle when ras_no first goes low. After exactly one clock with ras_no low, the bus switches to the column word. cas_no falls one clock after the switch.
- R7: cas_no stays low for CAS_CYCLES clocks (default 1). Then ras_no and cas_no rise at the same edge.
- R8: After the strobes rise, both stay high for PRE_CYCLES clocks (default 2) with busy_o still high. After that, busy_o goes low.
- R9: busy_o is high from the clock after a request is accepted until precharge ends. A req_i seen while busy_o is high is ignored, and the address and bank that were captured stay in use.
- R10: A req_i sampled high while idle is accepted whatever the value of phase_e_i. Address, bank and we_i are captured at that edge, so later changes on those inputs have no effect on the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phase_e_i | input | 1 | Bus-phase enable; the row strobe may fall only while it is high |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | 13 | Offset inside the 8 KB page |
| bank_i | input | 5 | Bank number from the page map |
| dram_addr_o | output | 9 | Multiplexed DRAM address bus |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe, active low |
| we0_no | output | 1 | Write enable for even bytes, active low |
| we1_no | output | 1 | Write enable for odd bytes, active low |
| busy_o | output | 1 | An access is in progress |

## Verification
The assertions check the following on every cycle:
- the row strobe falls only after phase_e_i was high;
- the address bus holds still across each strobe fall;
- the column strobe comes two clocks after the row strobe falls;
- the two strobes rise together;
- at most one lane enable is low, and only inside the row strobe;
- captured requests are frozen while the block is busy.

The following can only be shown by the bench scenarios, which compare against independently computed words:
- the exact bit scatter of the row and column words;
- the lane chosen by address bit 0;
- the length of the phase_e_i wait;
- the length of the precharge;
- ignoring requests made while busy.

// File: rtl/dram_mux_pkg.sv
package dram_mux_pkg;
  localparam int CPU_AW  = 13;
  localparam int BANK_W  = 5;
  localparam int DRAM_AW = 9;
  localparam int LANES   = 2;
  localparam int LANE_W  = $clog2(LANES);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ROW,
    ST_SWITCH,
    ST_CAS,
    ST_PRE
  } seq_state_e;

  typedef struct packed {
    logic [BANK_W-1:0] bank;
    logic [CPU_AW-1:0] off;
    logic              wr;
  } acc_req_t;
endpackage

// File: rtl/addr_scatter.sv
module addr_scatter
  import dram_mux_pkg::*;
(
  input  logic [CPU_AW-1:0]  off_i,
  input  logic [BANK_W-1:0]  bank_i,
  input  logic               col_sel_i,
  output logic [DRAM_AW-1:0] word_o
);
  localparam int LOW_LINES = DRAM_AW - 1;
  localparam int COL_OFF_N = CPU_AW - 1 - LOW_LINES;

  logic [DRAM_AW-1:0] row_w, col_w;

  for (genvar i = 0; i < LOW_LINES; i++) begin : g_line
    assign row_w[i] = off_i[i+1];
    if (i < COL_OFF_N) begin : g_off
      assign col_w[i] = off_i[i+1+LOW_LINES];
    end else begin : g_bank
      assign col_w[i] = bank_i[i-COL_OFF_N];
    end
  end

  // top bank bit rides in both words
  assign row_w[DRAM_AW-1] = bank_i[BANK_W-1];
  assign col_w[DRAM_AW-1] = bank_i[BANK_W-1];

  assign word_o = col_sel_i ? col_w : row_w;
endmodule

// File: rtl/lane_sel.sv
module lane_sel
  import dram_mux_pkg::*;
(
  input  logic [LANE_W-1:0] lane_i,
  input  logic              wr_i,
  input  logic              win_i,
  output logic [LANES-1:0]  we_no
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign we_no[l] = !(wr_i && win_i && (lane_i == LANE_W'(l)));
  end
endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dram_mux_pkg::*;
#(
  parameter int CAS_CYCLES = 1,
  parameter int PRE_CYCLES = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     req_i,
  input  logic     phase_e_i,
  input  acc_req_t req_d_i,
  output acc_req_t cur_o,
  output logic     ras_no,
  output logic     cas_no,
  output logic     col_sel_o,
  output logic     we_win_o,
  output logic     busy_o
);
  localparam int MAXC  = (CAS_CYCLES > PRE_CYCLES) ? CAS_CYCLES : PRE_CYCLES;
  localparam int CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam logic [CNT_W-1:0] CAS_LAST = CNT_W'(CAS_CYCLES - 1);
  localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(PRE_CYCLES - 1);

  seq_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  acc_req_t         cur_q;
  logic             accept;

  assign accept = (st_q == ST_IDLE) && req_i;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_IDLE:   if (req_i) st_d = ST_SETUP;
      ST_SETUP:  if (phase_e_i) st_d = ST_ROW;
      ST_ROW:    st_d = ST_SWITCH;
      ST_SWITCH: begin st_d = ST_CAS; cnt_d = '0; end
      ST_CAS: begin
        if (cnt_q == CAS_LAST) begin st_d = ST_PRE; cnt_d = '0; end
        else cnt_d = cnt_q + 1'b1;
      end
      ST_PRE: begin
        if (cnt_q == PRE_LAST) begin st_d = ST_IDLE; cnt_d = '0; end
        else cnt_d = cnt_q + 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      cur_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      if (accept) cur_q <= req_d_i;
    end
  end

  assign cur_o     = cur_q;
  assign ras_no    = !(st_q inside {ST_ROW, ST_SWITCH, ST_CAS});
  assign cas_no    = (st_q != ST_CAS);
  assign col_sel_o = st_q inside {ST_SWITCH, ST_CAS, ST_PRE};
  assign we_win_o  = st_q inside {ST_SWITCH, ST_CAS};
  assign busy_o    = (st_q != ST_IDLE);

  // R9
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(cur_q));
  // R5
  ras_needs_e_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_no) |-> $past(phase_e_i));
endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux
  import dram_mux_pkg::*;
#(
  parameter int CAS_CYCLES = 1,
  parameter int PRE_CYCLES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               phase_e_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [CPU_AW-1:0]  cpu_addr_i,
  input  logic [BANK_W-1:0]  bank_i,
  output logic [DRAM_AW-1:0] dram_addr_o,
  output logic               ras_no,
  output logic               cas_no,
  output logic               we0_no,
  output logic               we1_no,
  output logic               busy_o
);
  acc_req_t         req_d, cur;
  logic             col_sel, we_win;
  logic [LANES-1:0] we_n;

  assign req_d = '{bank: bank_i, off: cpu_addr_i, wr: we_i};

  dram_seq #(.CAS_CYCLES(CAS_CYCLES), .PRE_CYCLES(PRE_CYCLES)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .phase_e_i (phase_e_i),
    .req_d_i   (req_d),
    .cur_o     (cur),
    .ras_no    (ras_no),
    .cas_no    (cas_no),
    .col_sel_o (col_sel),
    .we_win_o  (we_win),
    .busy_o    (busy_o)
  );

  addr_scatter u_scatter (
    .off_i     (cur.off),
    .bank_i    (cur.bank),
    .col_sel_i (col_sel),
    .word_o    (dram_addr_o)
  );

  lane_sel u_lane (
    .lane_i (cur.off[LANE_W-1:0]),
    .wr_i   (cur.wr),
    .win_i  (we_win),
    .we_no  (we_n)
  );

  assign we0_no = we_n[0];
  assign we1_no = we_n[1];

  // R6
  row_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_no) |-> $stable(dram_addr_o));
  // R6
  col_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cas_no) |-> $stable(dram_addr_o));
  // R6
  cas_after_ras_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cas_no) |-> ($past(!ras_no, 2) && !ras_no));
  // R7
  strobe_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cas_no) |-> $rose(ras_no));
  // R4
  lane_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({we0_no, we1_no}) >= 1);
  // R4
  we_in_ras_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we0_no || !we1_no) |-> !ras_no);
endmodule

// File: tb/dram_addr_mux_test.sv
`timescale 1ns/1ps
module dram_addr_mux_test;
  localparam int CAS_C = 1;
  localparam int PRE_C = 2;

  logic clk = 0, rst_ni = 0;
  logic phase_e = 0, req = 0, we = 0;
  logic [12:0] addr = '0;
  logic [4:0]  bank = '0;
  logic [8:0]  dram_addr;
  logic ras_n, cas_n, we0_n, we1_n, busy;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  dram_addr_mux #(.CAS_CYCLES(CAS_C), .PRE_CYCLES(PRE_C)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .phase_e_i(phase_e), .req_i(req), .we_i(we),
    .cpu_addr_i(addr), .bank_i(bank), .dram_addr_o(dram_addr), .ras_no(ras_n),
    .cas_no(cas_n), .we0_no(we0_n), .we1_no(we1_n), .busy_o(busy));

  function automatic logic [8:0] exp_row(logic [12:0] a, logic [4:0] b);
    return {b[4], a[8:1]};
  endfunction
  function automatic logic [8:0] exp_col(logic [12:0] a, logic [4:0] b);
    return {b[4], b[3:0], a[12:9]};
  endfunction

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", r, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  // strobe vector {ras,cas,we0,we1,busy}
  task automatic chk_strobes(input logic [4:0] exp, input string r);
    chk({ras_n, cas_n, we0_n, we1_n, busy} === exp, r,
        {ras_n, cas_n, we0_n, we1_n, busy}, exp);
  endtask

  task automatic access(input logic [12:0] a, input logic [4:0] b, input bit w,
                        input int e_wait, input bit spam);
    logic [8:0] r = exp_row(a, b);
    logic [8:0] c = exp_col(a, b);
    logic [1:0] lane = w ? (a[0] ? 2'b10 : 2'b01) : 2'b11;
    @(negedge clk);
    req = 1; addr = a; bank = b; we = w; phase_e = (e_wait == 0) ? 1'b0 : 1'b1;
    step();
    // R10: scramble inputs after capture
    addr = ~a; bank = ~b; we = ~w;
    if (!spam) req = 0;
    for (int k = 0; k <= e_wait; k++) begin
      chk_strobes(5'b11111, "R5 wait");
      chk(dram_addr === r, "R5 row during wait", dram_addr, r);
      phase_e = (k == e_wait);
      step();
    end
    phase_e = 1'($urandom);
    chk_strobes(5'b01111, "R6 ras low");
    chk(dram_addr === r, "R2 row word", dram_addr, r);
    step();
    chk_strobes({2'b01, lane, 1'b1}, "R4 switch lane");
    chk(dram_addr === c, "R3 col word", dram_addr, c);
    step();
    for (int k = 0; k < CAS_C; k++) begin
      chk_strobes({2'b00, lane, 1'b1}, "R7 cas low");
      chk(dram_addr === c, "R9 col kept", dram_addr, c);
      step();
    end
    for (int k = 0; k < PRE_C; k++) begin
      if (k == PRE_C - 1) req = 0;
      chk_strobes(5'b11111, "R8 precharge");
      step();
    end
    chk_strobes(5'b11110, "R8 idle");
  endtask

  initial begin
    #(4 * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    #1;
    chk_strobes(5'b11110, "R1 in reset");
    repeat (3) @(negedge clk);
    rst_ni = 1;
    step();
    chk_strobes(5'b11110, "R1 after reset");
    chk(dram_addr === 9'd0, "R1 addr", dram_addr, 0);
    // directed corners
    access(13'h0000, 5'h10, 1'b1, 0, 0);
    access(13'h0001, 5'h00, 1'b1, 0, 0);
    access(13'h1FFF, 5'h1F, 1'b0, 3, 0);
    access(13'h1555, 5'h0A, 1'b1, 1, 1);
    access(13'h0AAA, 5'h15, 1'b1, 2, 1);
    // idle with E high and no request: nothing happens
    phase_e = 1;
    repeat (3) begin
      step();
      chk_strobes(5'b11110, "R10 no req");
    end
    for (int n = 0; n < 60; n++) begin
      access(13'($urandom), 5'($urandom), 1'($urandom),
             int'($urandom % 4), 1'($urandom));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule